// File: doc/BRIEF.md
# Serial Link Bring-Up Controller

This block is the link-level state machine of a point-to-point serial link with data/strobe signalling. After a system reset it walks the link through a fixed bring-up sequence: a short settle interval with everything held in reset, then a longer wait with the receiver running, then a ready state that waits for software to enable the link. Once enabled it sends NULLs, then NULLs and flow-control tokens, and finally grants full transmit permission once the far end has answered. Any error seen during bring-up drops the link back to the start of the sequence. The character encoder and decoder sit outside the block. The block receives single-cycle "character received" and error flags from the decoder and returns permission and reset levels to the encoder.

When the link fails while running, or software disables it, the block does not restart at once. It first enters a capture state. There it latches the cause of the failure into a status field, pulses a save strobe for one cycle and holds the transmitter in reset until the host acknowledges. Only then does the bring-up sequence begin again. The two bring-up intervals are given as clock-cycle counts, so the block can be used at any clock rate.

Top module: `lnk_bringup_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 and `tx_rst` and `rx_rst` are 1. `tx_null_ok`, `tx_fct_ok`, `tx_all_ok` and `save_stb` are 0, and `cause_o` is 0. The reset acts without waiting for a clock edge.
- R2: State 0 (error-reset) is left for state 1 (error-wait) exactly `SHORT_CYC` clock edges after it is entered or after reset is released. In state 1, `rx_rst` is 0 and `tx_rst` stays 1.
- R3: State 1 moves to state 2 (ready) exactly `LONG_CYC` edges after entry, unless an error ends it first. In state 2, `tx_rst` stays 1.
- R4: A NULL-seen flag is set by `rx_null` in every state except 0 and is cleared only in state 0. In states 1, 2 and 3, `err_disc` always returns the block to state 0. While the flag is set, `err_par`, `err_esc`, `rx_fct`, `rx_nchar` or `rx_tcode` also return it to state 0. Before the flag is set, those inputs are ignored.
- R5: State 2 moves to state 3 (started) on the edge where `link_en` is 1. It waits in state 2 while `link_en` is 0.
- R6: In state 3 only `tx_null_ok` is granted. The block moves to state 4 (connecting) on the first edge where `rx_null` is 1 or the NULL-seen flag is set. If neither happens within `LONG_CYC` edges of entry, it returns to state 0.
- R7: In state 4, `tx_null_ok` and `tx_fct_ok` are 1. `rx_fct` moves the block to state 5 (run). `err_disc`, `err_par`, `err_esc`, `rx_nchar`, `rx_tcode`, or `LONG_CYC` edges in the state return it to state 0.
- R8: In state 5 all three transmit permissions are 1. `link_en` low or any of `err_disc`, `err_par`, `err_esc` or `err_credit` moves the block to state 6 (capture). On that edge `cause_o` latches bit0 disconnect, bit1 parity, bit2 escape, bit3 credit and bit4 link disabled. It holds this value until the next entry to state 6.
- R9: `save_stb` is 1 during the first cycle in state 6 only. The block holds `tx_rst` at 1 in state 6 and moves to state 0 on the edge where `host_ack` is 1.
- R10: `state_o` encodes the states as 0 error-reset, 1 error-wait, 2 ready, 3 started, 4 connecting, 5 run and 6 capture. `tx_rst` is 1 exactly in states 0, 1, 2 and 6, and `rx_rst` is 1 only in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| link_en | input | 1 | Link enable from software |
| rx_null | input | 1 | NULL received (one-cycle flag) |
| rx_fct | input | 1 | Flow-control token received |
| rx_nchar | input | 1 | Data or end-of-packet character received |
| rx_tcode | input | 1 | Time-code received |
| err_disc | input | 1 | Disconnect error |
| err_par | input | 1 | Parity error |
| err_esc | input | 1 | Escape error |
| err_credit | input | 1 | Credit error |
| host_ack | input | 1 | Host has saved and read the error record |
| tx_rst | output | 1 | Transmitter held in reset |
| rx_rst | output | 1 | Receiver held in reset |
| tx_null_ok | output | 1 | Transmitter may send NULLs |
| tx_fct_ok | output | 1 | Transmitter may send flow-control tokens |
| tx_all_ok | output | 1 | Transmitter may send data and time-codes |
| state_o | output | 3 | Current state code |
| cause_o | output | 5 | Latched failure cause |
| save_stb | output | 1 | One-cycle strobe asking the host to save the error record |

## Verification
Some rules can be checked on every cycle, and the embedded assertions cover these. They check that error-wait is entered only after the short interval has run out and that run is entered only from connecting on a received flow-control token. They also check that capture is entered only from run, that capture is left only on an acknowledge, that the save strobe never lasts two cycles, and that the NULL-seen flag stays set outside error-reset. Other behaviour depends on timing and on the order of events, and only the bench scenarios show it. These are the exact length of each interval, the rule that parity errors count only after a NULL, the started and connecting timeouts, the cause bits latched for a combined disable and credit failure, and the asynchronous reset in the middle of the sequence.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
   localparam int STW   = 3;
   localparam int CAUSW = 5;

   typedef enum logic [STW-1:0] {
      ST_ERST  = 3'd0,
      ST_EWAIT = 3'd1,
      ST_READY = 3'd2,
      ST_START = 3'd3,
      ST_CONN  = 3'd4,
      ST_RUN   = 3'd5,
      ST_CAPT  = 3'd6
   } lnk_state_e;

   // cause bit positions
   localparam int CB_DISC = 0;
   localparam int CB_PAR  = 1;
   localparam int CB_ESC  = 2;
   localparam int CB_CRED = 3;
   localparam int CB_DIS  = 4;
endpackage

// File: rtl/lnk_tmr.sv
module lnk_tmr #(
   parameter int SHORT_CYC = 64,
   parameter int LONG_CYC  = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic short_done,
   output logic long_done
);
   localparam int CW  = $clog2(LONG_CYC + 1);
   localparam int LIM = LONG_CYC - 1;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (cnt_q < CW'(LIM))
         cnt_q <= cnt_q + 1'b1;
   end

   assign short_done = (cnt_q >= CW'(SHORT_CYC - 1));
   assign long_done  = (cnt_q >= CW'(LIM));

   AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIM)); // R3
   AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/lnk_errcap.sv
module lnk_errcap
   import lnk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [CAUSW-1:0] cause_in,
   output logic [CAUSW-1:0] cause_q,
   output logic             save_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
         save_q  <= 1'b0;
      end else begin
         save_q <= capture;
         if (capture)
            cause_q <= cause_in;
      end
   end

   AST_SAVE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      save_q |=> !save_q); // R9
   AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> $stable(cause_q)); // R8
endmodule

// File: rtl/lnk_bringup_ctrl.sv
module lnk_bringup_ctrl
   import lnk_pkg::*;
#(
   parameter int SHORT_CYC = 64,
   parameter int LONG_CYC  = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_en,
   input  logic             rx_null,
   input  logic             rx_fct,
   input  logic             rx_nchar,
   input  logic             rx_tcode,
   input  logic             err_disc,
   input  logic             err_par,
   input  logic             err_esc,
   input  logic             err_credit,
   input  logic             host_ack,
   output logic             tx_rst,
   output logic             rx_rst,
   output logic             tx_null_ok,
   output logic             tx_fct_ok,
   output logic             tx_all_ok,
   output logic [STW-1:0]   state_o,
   output logic [CAUSW-1:0] cause_o,
   output logic             save_stb
);
   initial begin
      assert (SHORT_CYC >= 2 && LONG_CYC > SHORT_CYC)
         else $fatal(1, "lnk_bringup_ctrl: need 2 <= SHORT_CYC < LONG_CYC");
   end

   lnk_state_e st_q, st_d;
   logic       null_seen_q;
   logic       short_done, long_done;
   logic       err_init, err_conn, err_run;
   logic       enter_capt;
   logic [CAUSW-1:0] cause_now;

   // interval timer, restarted on every state change
   lnk_tmr #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (st_d != st_q),
      .short_done (short_done),
      .long_done  (long_done)
   );

   // sticky NULL-seen flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         null_seen_q <= 1'b0;
      else if (st_q == ST_ERST)
         null_seen_q <= 1'b0;
      else if (rx_null)
         null_seen_q <= 1'b1;
   end

   assign err_init = err_disc |
                     (null_seen_q & (err_par | err_esc | rx_fct | rx_nchar | rx_tcode));
   assign err_conn = err_disc | err_par | err_esc | rx_nchar | rx_tcode | long_done;
   assign err_run  = !link_en | err_disc | err_par | err_esc | err_credit;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_ERST:  if (short_done) st_d = ST_EWAIT;
         ST_EWAIT: if (err_init) st_d = ST_ERST;
                   else if (long_done) st_d = ST_READY;
         ST_READY: if (err_init) st_d = ST_ERST;
                   else if (link_en) st_d = ST_START;
         ST_START: if (err_init) st_d = ST_ERST;
                   else if (null_seen_q | rx_null) st_d = ST_CONN;
                   else if (long_done) st_d = ST_ERST;
         ST_CONN:  if (err_conn) st_d = ST_ERST;
                   else if (rx_fct) st_d = ST_RUN;
         ST_RUN:   if (err_run) st_d = ST_CAPT;
         ST_CAPT:  if (host_ack) st_d = ST_ERST;
         default:  st_d = ST_ERST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= ST_ERST;
      else
         st_q <= st_d;
   end

   // error record capture
   always_comb begin
      cause_now          = '0;
      cause_now[CB_DISC] = err_disc;
      cause_now[CB_PAR]  = err_par;
      cause_now[CB_ESC]  = err_esc;
      cause_now[CB_CRED] = err_credit;
      cause_now[CB_DIS]  = !link_en;
   end

   assign enter_capt = (st_q == ST_RUN) && (st_d == ST_CAPT);

   lnk_errcap u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (enter_capt),
      .cause_in (cause_now),
      .cause_q  (cause_o),
      .save_q   (save_stb)
   );

   // permission decode
   assign tx_rst     = (st_q == ST_ERST) || (st_q == ST_EWAIT) ||
                       (st_q == ST_READY) || (st_q == ST_CAPT);
   assign rx_rst     = (st_q == ST_ERST);
   assign tx_null_ok = (st_q == ST_START) || (st_q == ST_CONN) || (st_q == ST_RUN);
   assign tx_fct_ok  = (st_q == ST_CONN) || (st_q == ST_RUN);
   assign tx_all_ok  = (st_q == ST_RUN);
   assign state_o    = st_q;

   AST_EWAIT_AFTER_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_EWAIT && $past(st_q) == ST_ERST) |-> $past(short_done)); // R2
   AST_NULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (null_seen_q && st_q != ST_ERST) |=> null_seen_q); // R4
   AST_RUN_FROM_CONN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && $past(st_q) != ST_RUN) |->
         ($past(st_q) == ST_CONN && $past(rx_fct))); // R7
   AST_CAPT_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CAPT && $past(st_q) != ST_CAPT) |-> $past(st_q) == ST_RUN); // R8
   AST_CAPT_EXIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == ST_CAPT && st_q != ST_CAPT) |->
         ($past(host_ack) && st_q == ST_ERST)); // R9
   AST_SAVE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      save_stb |-> (st_q == ST_CAPT && $past(st_q) == ST_RUN)); // R9
   AST_PERM_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_rst && tx_null_ok) && (!tx_all_ok || tx_fct_ok) && (!tx_fct_ok || tx_null_ok)); // R10
endmodule

// File: tb/lnk_bringup_ctrl_tb.sv
module lnk_bringup_ctrl_tb;
   localparam int CLK_PER = 10;
   localparam int SH = 4;
   localparam int LG = 8;

   // input vector bits
   localparam int I_ACK = 1 << 0;
   localparam int I_CRD = 1 << 1;
   localparam int I_ESC = 1 << 2;
   localparam int I_PAR = 1 << 3;
   localparam int I_DSC = 1 << 4;
   localparam int I_TC  = 1 << 5;
   localparam int I_NCH = 1 << 6;
   localparam int I_FCT = 1 << 7;
   localparam int I_NUL = 1 << 8;
   localparam int I_EN  = 1 << 9;

   localparam int NROW = 31;
   // {inputs[10], edges[8], exp state[3], exp save[1], req[4]}
   localparam logic [25:0] TBL [0:NROW-1] = '{
      {10'(0),           8'd3, 3'd0, 1'b0, 4'd2},  // R2 still settling
      {10'(0),           8'd1, 3'd1, 1'b0, 4'd2},  // R2 short interval done
      {10'(0),           8'd7, 3'd1, 1'b0, 4'd3},  // R3
      {10'(0),           8'd1, 3'd2, 1'b0, 4'd3},  // R3 long interval done
      {10'(0),           8'd3, 3'd2, 1'b0, 4'd5},  // R5 waits for enable
      {10'(I_EN),        8'd1, 3'd3, 1'b0, 4'd5},  // R5
      {10'(I_EN),        8'd5, 3'd3, 1'b0, 4'd6},  // R6
      {10'(I_EN|I_NUL),  8'd1, 3'd4, 1'b0, 4'd6},  // R6 null -> connecting
      {10'(I_EN|I_NUL),  8'd3, 3'd4, 1'b0, 4'd7},  // R7
      {10'(I_EN|I_FCT),  8'd1, 3'd5, 1'b0, 4'd7},  // R7 fct -> run
      {10'(I_EN|I_NCH),  8'd4, 3'd5, 1'b0, 4'd8},  // R8 chars fine in run
      {10'(I_EN|I_PAR),  8'd1, 3'd6, 1'b1, 4'd8},  // R8 parity -> capture
      {10'(I_EN),        8'd3, 3'd6, 1'b0, 4'd9},  // R9 waits for ack
      {10'(I_ACK),       8'd1, 3'd0, 1'b0, 4'd9},  // R9
      {10'(0),           8'd4, 3'd1, 1'b0, 4'd2},  // R2
      {10'(I_PAR),       8'd1, 3'd1, 1'b0, 4'd4},  // R4 parity ignored before null
      {10'(I_NUL),       8'd1, 3'd1, 1'b0, 4'd4},  // R4
      {10'(I_PAR),       8'd1, 3'd0, 1'b0, 4'd4},  // R4 parity after null
      {10'(0),           8'd4, 3'd1, 1'b0, 4'd2},  // R2
      {10'(I_DSC),       8'd1, 3'd0, 1'b0, 4'd4},  // R4 disconnect
      {10'(0),           8'd4, 3'd1, 1'b0, 4'd2},  // R2
      {10'(0),           8'd8, 3'd2, 1'b0, 4'd3},  // R3
      {10'(I_NUL),       8'd1, 3'd2, 1'b0, 4'd4},  // R4 null in ready
      {10'(I_EN),        8'd1, 3'd3, 1'b0, 4'd5},  // R5
      {10'(I_EN),        8'd1, 3'd4, 1'b0, 4'd6},  // R6 sticky flag
      {10'(I_EN),        8'd7, 3'd4, 1'b0, 4'd7},  // R7
      {10'(I_EN),        8'd1, 3'd0, 1'b0, 4'd7},  // R7 connecting timeout
      {10'(0),           8'd4, 3'd1, 1'b0, 4'd2},  // R2
      {10'(0),           8'd8, 3'd2, 1'b0, 4'd3},  // R3
      {10'(I_EN),        8'd1, 3'd3, 1'b0, 4'd5},  // R5
      {10'(I_EN),        8'd8, 3'd0, 1'b0, 4'd6}   // R6 started timeout
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] vin = '0;
   logic       tx_rst, rx_rst, tx_null_ok, tx_fct_ok, tx_all_ok, save_stb;
   logic [2:0] state_o;
   logic [4:0] cause_o;
   int         n_chk = 0;
   int         n_bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   lnk_bringup_ctrl #(.SHORT_CYC(SH), .LONG_CYC(LG)) u_dut (
      .clk(clk), .rst_n(rst_n), .link_en(vin[9]), .rx_null(vin[8]),
      .rx_fct(vin[7]), .rx_nchar(vin[6]), .rx_tcode(vin[5]),
      .err_disc(vin[4]), .err_par(vin[3]), .err_esc(vin[2]),
      .err_credit(vin[1]), .host_ack(vin[0]),
      .tx_rst(tx_rst), .rx_rst(rx_rst), .tx_null_ok(tx_null_ok),
      .tx_fct_ok(tx_fct_ok), .tx_all_ok(tx_all_ok), .state_o(state_o),
      .cause_o(cause_o), .save_stb(save_stb)
   );

   // {tx_rst, rx_rst, null_ok, fct_ok, all_ok} per state, from R10 and R6-R8
   function automatic logic [4:0] exp_out(input logic [2:0] st);
      case (st)
         3'd0:    return 5'b11000;
         3'd3:    return 5'b00100;
         3'd4:    return 5'b00110;
         3'd5:    return 5'b00111;
         default: return 5'b10000;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic apply(input logic [9:0] v, input int edges);
      vin = v;
      repeat (edges) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [4:0] outs();
      return {tx_rst, rx_rst, tx_null_ok, tx_fct_ok, tx_all_ok};
   endfunction

   initial begin
      #(CLK_PER * 150000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 state", state_o, 0);
      chk("R1 outs", outs(), 5'b11000);
      chk("R1 save", save_stb, 0);
      chk("R1 cause", cause_o, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NROW; i++) begin
         automatic logic [25:0] e = TBL[i];
         apply(e[25:16], int'(e[15:8]));
         chk($sformatf("R%0d state row %0d", e[3:0], i), state_o, e[7:5]);
         chk($sformatf("R10 outs row %0d", i), outs(), exp_out(e[7:5]));
         chk($sformatf("R9 save row %0d", i), save_stb, e[4]);
      end
      chk("R8 parity cause", cause_o, 5'b00010);

      // R8 combined disable + credit cause
      apply(10'(0), SH);
      apply(10'(0), LG);
      apply(10'(I_EN), 1);
      apply(10'(I_EN|I_NUL), 1);
      apply(10'(I_EN|I_FCT), 1);
      chk("R7 run", state_o, 5);
      apply(10'(I_CRD), 1);
      chk("R8 capture", state_o, 6);
      chk("R8 cause", cause_o, 5'b11000);
      chk("R9 strobe", save_stb, 1);
      apply(10'(0), 1);
      chk("R9 strobe once", save_stb, 0);
      chk("R9 tx held", tx_rst, 1);
      apply(10'(I_ACK), 1);
      chk("R9 ack exit", state_o, 0);
      chk("R8 cause held", cause_o, 5'b11000);

      // R7 time-code in connecting
      apply(10'(0), SH);
      apply(10'(0), LG);
      apply(10'(I_EN|I_NUL), 1);
      apply(10'(I_EN), 1);
      chk("R7 conn", state_o, 4);
      apply(10'(I_EN|I_TC), 1);
      chk("R7 tcode", state_o, 0);

      // R1 asynchronous reset mid-sequence
      apply(10'(0), SH);
      chk("R2 wait", state_o, 1);
      #(CLK_PER/4);
      rst_n = 1'b0;
      #1;
      chk("R1 async state", state_o, 0);
      chk("R1 async outs", outs(), 5'b11000);
      chk("R1 async cause", cause_o, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule